// File: doc/BRIEF.md
# Read-Strobe Watchdog Timer

This block is a system watchdog that software controls only through I/O read cycles on a small host bus. A read of the arm/kick address starts the watchdog when it is idle and restarts the countdown when it is already running. A read of a separate disarm address stops it and cancels any pending timeout. The data returned by the read does not matter. Only a read cycle whose address matches has an effect.

The timeout length is one of six fixed periods, from 1 s to 220 s, chosen by a 3-bit strap. Time is counted on a one-cycle `tick_1s` enable, so a bench can compress seconds into single clock cycles. When the countdown runs out, the block raises either a 16-cycle reset pulse or a one-cycle NMI, as a second strap selects. It then returns to the disarmed state.

Top module: `iotrig_watchdog`

## Requirements
- R1: After synchronous reset `rst`, the watchdog is disarmed and both `rst_out` and `nmi_out` are low.
- R2: An `io_rd` pulse with `io_addr` = 0x0443 arms an idle watchdog and loads the selected period. On an armed watchdog, the same read reloads the period and restarts the countdown.
- R3: An `io_rd` pulse with `io_addr` = 0x0045 disarms the watchdog. No timeout follows it, even when it coincides with the final tick.
- R4: A cycle with `io_rd` low, or a read at any other address, has no effect on the countdown.
- R5: `period_sel` = {strap A, strap B, strap C}, where 1 means the jumper is fitted. The codes map to periods as follows: 111 → 1 s, 011 → 2 s, 101 → 10 s, 001 → 20 s, 110 → 110 s, 010 → 220 s. The unused codes 000 and 100 give 1 s.
- R6: While armed, the count drops by one on each `tick_1s` cycle. With a period of P, the timeout is issued on the P-th tick after the last kick, and no output appears before it.
- R7: With `nmi_mode` = 0, a timeout drives `rst_out` high for exactly 16 consecutive cycles, starting in the cycle after the expiring tick.
- R8: With `nmi_mode` = 1, a timeout drives `nmi_out` high for exactly one cycle, in the cycle after the expiring tick, and `rst_out` stays low.
- R9: After a timeout the watchdog is disarmed. Further ticks produce no output until it is armed again.
- R10: `period_sel` is sampled only when a kick occurs. A change made while counting takes effect at the next kick.
- R11: When a kick read and the final tick arrive in the same cycle, the kick wins, no timeout is issued, and the full period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_addr | input | 16 | I/O address of the read |
| tick_1s | input | 1 | One-cycle seconds enable |
| period_sel | input | 3 | Period strap {A,B,C} |
| nmi_mode | input | 1 | Timeout action: 0 reset pulse, 1 NMI |
| rst_out | output | 1 | System reset pulse |
| nmi_out | output | 1 | NMI pulse |

## Verification
The hardest cases to reach are the same-cycle collisions: a kick read or a disarm read landing on the very tick that would take the count from one to zero. From the ports these look identical to ordinary kicks unless the tick is aligned exactly. The bench arms with the 1-second code, so that the next tick is the final one, and then drives the read and `tick_1s` in the same cycle. It then checks that no pulse appears and that, for the kick case, exactly one more tick is still needed. The 220-second period is reached by driving a tick on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W  = 3;
  localparam int SECS_W = 8;

  // Period lookup: strap order {A,B,C}, 1 = fitted. Unused codes give 1 s.
  function automatic logic [SECS_W-1:0] period_secs(input logic [SEL_W-1:0] sel);
    logic [SECS_W-1:0] s;
    case (sel)
      3'b111:  s = 8'd1;
      3'b011:  s = 8'd2;
      3'b101:  s = 8'd10;
      3'b001:  s = 8'd20;
      3'b110:  s = 8'd110;
      3'b010:  s = 8'd220;
      default: s = 8'd1;
    endcase
    return s;
  endfunction

  // True when the countdown is on its last second.
  function automatic logic is_last(input logic [SECS_W-1:0] c);
    return c == SECS_W'(1);
  endfunction
endpackage

// File: rtl/wdt_addr_decode.sv
module wdt_addr_decode #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] KICK_ADDR   = 16'h0443,
  parameter logic [15:0] DISARM_ADDR = 16'h0045
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              kick,
  output logic              disarm
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KICK_ADDR);
  localparam logic [ADDR_W-1:0] DA = ADDR_W'(DISARM_ADDR);

  always_comb begin
    kick   = rd && (addr == KA);
    disarm = rd && (addr == DA);
  end
endmodule

// File: rtl/wdt_period_lut.sv
module wdt_period_lut #(
  parameter int CNT_W = 8
) (
  input  logic [wdt_pkg::SEL_W-1:0] sel,
  output logic [CNT_W-1:0]          secs
);
  generate
    if (CNT_W >= wdt_pkg::SECS_W) begin : g_wide
      assign secs = CNT_W'(wdt_pkg::period_secs(sel));
    end else begin : g_narrow
      assign secs = wdt_pkg::period_secs(sel)[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             disarm,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic last_sec;
  assign last_sec = (cnt == CNT_W'(1));
  // A kick or a disarm in the same cycle overrides the final tick.
  assign expire = armed && tick && last_sec && !kick && !disarm;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (disarm) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (kick) begin
      armed <= 1'b1;
      cnt   <= load_val;
    end else if (expire) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && tick) begin
      cnt   <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_alarm_out.sv
module wdt_alarm_out #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic nmi_mode,
  output logic rst_out,
  output logic nmi_out
);
  localparam int RW = $clog2(RST_CYC + 1);
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt    <= '0;
      nmi_out <= 1'b0;
    end else begin
      nmi_out <= expire && nmi_mode;
      if (expire && !nmi_mode)
        rcnt <= RW'(RST_CYC);
      else if (rcnt != '0)
        rcnt <= rcnt - RW'(1);
    end
  end

  assign rst_out = (rcnt != '0);
endmodule

// File: rtl/iotrig_watchdog.sv
module iotrig_watchdog #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] KICK_ADDR   = 16'h0443,
  parameter logic [15:0] DISARM_ADDR = 16'h0045,
  parameter int          CNT_W       = 8,
  parameter int          RST_CYC     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              tick_1s,
  input  logic [2:0]        period_sel,
  input  logic              nmi_mode,
  output logic              rst_out,
  output logic              nmi_out
);
  logic             kick;
  logic             disarm;
  logic             armed;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  wdt_addr_decode #(
    .ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR), .DISARM_ADDR(DISARM_ADDR)
  ) u_dec (
    .rd(io_rd), .addr(io_addr), .kick(kick), .disarm(disarm)
  );

  wdt_period_lut #(.CNT_W(CNT_W)) u_lut (
    .sel(period_sel), .secs(load_val)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk(clk), .rst(rst), .kick(kick), .disarm(disarm), .tick(tick_1s),
    .load_val(load_val), .armed(armed), .cnt(cnt), .expire(expire)
  );

  wdt_alarm_out #(.RST_CYC(RST_CYC)) u_out (
    .clk(clk), .rst(rst), .expire(expire), .nmi_mode(nmi_mode),
    .rst_out(rst_out), .nmi_out(nmi_out)
  );
endmodule

// File: rtl/iotrig_watchdog_chk.sv
module iotrig_watchdog_chk #(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             kick,
  input logic             disarm,
  input logic             armed,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             nmi_mode,
  input logic             rst_out,
  input logic             nmi_out
);
  logic [7:0] since_exp;
  always_ff @(posedge clk) begin
    if (rst)             since_exp <= 8'hFF;
    else if (expire)     since_exp <= 8'd1;
    else if (since_exp != 8'hFF) since_exp <= since_exp + 8'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!rst_out && !nmi_out && !armed));
  a_r3_disarm_stops: assert property (@(posedge clk) disable iff (rst)
    disarm |=> !armed);
  a_r11_kick_beats_expire: assert property (@(posedge clk) disable iff (rst)
    kick |-> !expire);
  a_r6_armed_count_live: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt != '0));
  a_r9_expire_disarms: assert property (@(posedge clk) disable iff (rst)
    expire |=> !armed);
  a_r8_nmi_one_cycle: assert property (@(posedge clk) disable iff (rst)
    nmi_out |=> !nmi_out);
  a_r8_nmi_from_expire: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_out) |-> ($past(expire) && $past(nmi_mode)));
  a_r7_rst_from_expire: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> ($past(expire) && !$past(nmi_mode)));
  a_r7_rst_window: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> (since_exp >= 8'd1 && since_exp <= 8'(RST_CYC)));
endmodule

bind iotrig_watchdog iotrig_watchdog_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst(rst), .kick(kick), .disarm(disarm), .armed(armed),
  .expire(expire), .cnt(cnt), .nmi_mode(nmi_mode),
  .rst_out(rst_out), .nmi_out(nmi_out)
);

// File: tb/iotrig_watchdog_tb_top.sv
module iotrig_watchdog_tb_top;
  localparam logic [15:0] KA = 16'h0443;
  localparam logic [15:0] DA = 16'h0045;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic tick_1s = 1'b0;
  logic [2:0] period_sel = 3'b111;
  logic nmi_mode = 1'b0;
  logic rst_out, nmi_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iotrig_watchdog dut_i (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr), .tick_1s(tick_1s),
    .period_sel(period_sel), .nmi_mode(nmi_mode),
    .rst_out(rst_out), .nmi_out(nmi_out)
  );

  // {sel, seconds}: periods restated from R5
  localparam logic [10:0] VEC [8] = '{
    {3'b111, 8'd1},   {3'b011, 8'd2},  {3'b101, 8'd10}, {3'b001, 8'd20},
    {3'b110, 8'd110}, {3'b010, 8'd220}, {3'b000, 8'd1}, {3'b100, 8'd1}
  };

  task automatic cyc(input logic rd, input logic [15:0] a, input logic tk);
    io_rd = rd; io_addr = a; tick_1s = tk;
    @(posedge clk); #1;
    io_rd = 1'b0; io_addr = '0; tick_1s = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state; a tick alone must not fire
    chk(!rst_out && !nmi_out, "R1", {rst_out, nmi_out}, 0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(!rst_out, "R1 idle tick", rst_out, 0);

    // R5 / R6 table walk in reset mode
    for (int i = 0; i < 8; i++) begin
      int secs;
      bit early;
      secs = int'(VEC[i][7:0]);
      early = 1'b0;
      period_sel = VEC[i][10:8];
      cyc(1'b1, KA, 1'b0);
      for (int t = 0; t < secs - 1; t++) begin
        cyc(1'b0, 16'h0, 1'b1);
        if (rst_out || nmi_out) early = 1'b1;
      end
      chk(!early, "R6 no early fire", early, 0);
      cyc(1'b0, 16'h0, 1'b1);
      chk(rst_out == 1'b1, "R5 period", rst_out, 1);
      idle(20);
    end

    // R7 pulse length
    period_sel = 3'b111;
    cyc(1'b1, KA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    begin
      int hi;
      hi = rst_out ? 1 : 0;
      for (int k = 0; k < 30; k++) begin
        cyc(1'b0, 16'h0, 1'b0);
        if (rst_out) hi++;
      end
      chk(hi == 16, "R7 width", hi, 16);
    end
    // R9 disarmed after timeout
    for (int k = 0; k < 5; k++) cyc(1'b0, 16'h0, 1'b1);
    chk(!rst_out && !nmi_out, "R9", rst_out, 0);

    // R8 NMI mode
    nmi_mode = 1'b1;
    cyc(1'b1, KA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(nmi_out && !rst_out, "R8 nmi", nmi_out, 1);
    cyc(1'b0, 16'h0, 1'b0);
    chk(!nmi_out && !rst_out, "R8 one cycle", nmi_out, 0);
    nmi_mode = 1'b0;
    idle(3);

    // R2 refresh restarts count (2 s)
    period_sel = 3'b011;
    cyc(1'b1, KA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b1, KA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(!rst_out, "R2 refresh held off", rst_out, 0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(rst_out, "R2 fire after refresh", rst_out, 1);
    idle(20);

    // R4 strobe-less matching address and other address ignored
    cyc(1'b1, KA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, KA, 1'b0);
    cyc(1'b1, 16'h0444, 1'b0);
    cyc(1'b0, DA, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(rst_out, "R4 no effect", rst_out, 1);
    idle(20);

    // R3 disarm then ticks
    cyc(1'b1, KA, 1'b0);
    cyc(1'b1, DA, 1'b0);
    for (int k = 0; k < 5; k++) cyc(1'b0, 16'h0, 1'b1);
    chk(!rst_out, "R3 disarm", rst_out, 0);
    // R3 disarm on final tick
    period_sel = 3'b111;
    cyc(1'b1, KA, 1'b0);
    cyc(1'b1, DA, 1'b1);
    chk(!rst_out, "R3 disarm on last tick", rst_out, 0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(!rst_out, "R3 stays disarmed", rst_out, 0);

    // R11 kick on final tick wins
    cyc(1'b1, KA, 1'b0);
    cyc(1'b1, KA, 1'b1);
    chk(!rst_out, "R11 kick wins", rst_out, 0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(rst_out, "R11 period restarted", rst_out, 1);
    idle(20);

    // R10 strap change while counting ignored until next kick
    period_sel = 3'b111;
    cyc(1'b1, KA, 1'b0);
    period_sel = 3'b010;
    cyc(1'b0, 16'h0, 1'b1);
    chk(rst_out, "R10 sampled at kick", rst_out, 1);
    idle(20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule